// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Packing Modes

This block sits between a register-write path and a serial audio encoder. Each 32-bit write carries audio in one of several packings: a single stereo channel sample, two 16-bit or two 8-bit samples (one for each channel), or a mono sample. The block unpacks every write into channel samples and holds up to eight left/right pairs, or eight mono samples. The serializer pulls one channel sample per read, always left first and then right. A mono sample is handed out twice, once for each channel.

A level output counts stored channel samples on a 0 to 16 scale, and a mono sample counts as two. A flag tells software whether the next stereo write fills the right channel. Writes that do not fit are dropped and set a sticky overflow flag. A synchronous flush empties the block.

Top module: `afifo_tx`

## Requirements
- R1: With `wr_mode`=0 (stereo), the first write is the left sample and the second is the right sample, each a full MSB-aligned 32-bit word. Reads return the left sample with `rd_right`=0 and then the right sample with `rd_right`=1.
- R2: With `wr_mode`=1 and `wr_compact8`=0, one write carries two samples: the right sample in bits 31:16 and the left sample in bits 15:0. Each is read out in bits 31:16 of `rd_data`, and bits 15:0 are zero.
- R3: With `wr_mode`=1 and `wr_compact8`=1, one write carries two samples: the right sample in bits 15:8 and the left sample in bits 7:0. Each is read out in bits 31:24 of `rd_data`, and bits 23:0 are zero. Bits 31:16 of the write are unused.
- R4: With `wr_mode`=2 (mono), one write stores one sample. It is read twice with the same value, first tagged left and then tagged right.
- R5: `level` goes up by 1 for each accepted stereo-mode write and by 2 for each accepted compact or mono write. It goes down by 1 for each accepted read, and it never leaves the range 0 to 16.
- R6: `next_right` is 0 after reset or flush. It becomes 1 after an accepted stereo left write and returns to 0 after the matching right write.
- R7: A left sample whose right partner has not yet been written counts in `level` but cannot be read. A read in that state reports empty.
- R8: A compact or mono write, or a stereo left write, made while eight pairs are stored is dropped. It sets `overflow`, which stays set until reset or flush. Room is judged on the occupancy at the start of the cycle, so a read in the same cycle does not make room for the write.
- R9: A compact or mono write made while a left sample waits for its partner is ignored, as is any write with `wr_mode`=3. Neither changes the level, the flag, the stored data or `overflow`.
- R10: Read data appears one cycle after `rd_en` with `rd_valid`=1. A read with nothing readable gives `rd_empty`=1 one cycle later, with `rd_valid`=0 and `rd_data`=0.
- R11: `flush` clears the stored samples, `level`, `next_right` and `overflow`, and it overrides any write or read in the same cycle.
- R12: Samples leave in the order they were written, across any mix of modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of contents and flags |
| wr_en | input | 1 | Write strobe |
| wr_mode | input | 2 | Packing: 0 stereo, 1 compact, 2 mono, 3 reserved |
| wr_compact8 | input | 1 | In compact mode: 1 selects 8-bit samples, 0 selects 16-bit samples |
| wr_data | input | 32 | Write word |
| next_right | output | 1 | Next stereo write fills the right channel |
| rd_en | input | 1 | Serializer read request |
| rd_valid | output | 1 | `rd_data` holds a sample |
| rd_data | output | 32 | MSB-aligned channel sample |
| rd_right | output | 1 | Returned sample belongs to the right channel |
| rd_empty | output | 1 | The previous read found nothing readable |
| level | output | 5 | Stored channel samples, 0 to 16 |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
A write and a read can be accepted in the same cycle. The level must then add the write's weight and subtract the read in one update, and the room check must use the occupancy from the start of the cycle. The directed part provokes this case at full occupancy, so a write meets a read that pops the head pair. The random part issues reads and writes together in roughly a quarter of its cycles, across all modes. In both parts, a bench model that holds pairs, the half-read state and the waiting left sample predicts every output in every cycle.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    MODE_STEREO  = 2'd0,
    MODE_COMPACT = 2'd1,
    MODE_MONO    = 2'd2,
    MODE_RSVD    = 2'd3
  } wr_mode_e;

  typedef struct packed {
    logic [SAMPLE_W-1:0] right;
    logic [SAMPLE_W-1:0] left;
  } pair_t;

  function automatic logic [SAMPLE_W-1:0] top_align16(input logic [15:0] s);
    return {s, {(SAMPLE_W-16){1'b0}}};
  endfunction

  function automatic logic [SAMPLE_W-1:0] top_align8(input logic [7:0] s);
    return {s, {(SAMPLE_W-8){1'b0}}};
  endfunction
endpackage

// File: rtl/afifo_packer.sv
module afifo_packer
  import afifo_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [1:0]          wr_mode,
  input  logic                wr_compact8,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                full,
  output logic                commit,
  output pair_t               commit_pair,
  output logic [1:0]          lvl_add,
  output logic                ovf_evt,
  output logic                next_right
);
  logic                staged;
  logic [SAMPLE_W-1:0] hold;
  logic                stage_set;
  logic                stage_clr;
  wr_mode_e            mode;

  assign mode       = wr_mode_e'(wr_mode);
  assign next_right = staged;

  always_comb begin
    commit      = 1'b0;
    lvl_add     = 2'd0;
    ovf_evt     = 1'b0;
    stage_set   = 1'b0;
    stage_clr   = 1'b0;
    commit_pair = '{right: wr_data, left: hold};
    if (wr_en && !flush) begin
      case (mode)
        MODE_STEREO: begin
          if (staged) begin
            commit    = 1'b1;
            lvl_add   = 2'd1;
            stage_clr = 1'b1;
          end else if (full) begin
            ovf_evt = 1'b1;
          end else begin
            stage_set = 1'b1;
            lvl_add   = 2'd1;
          end
        end
        MODE_COMPACT: begin
          if (!staged) begin
            if (full) begin
              ovf_evt = 1'b1;
            end else begin
              commit  = 1'b1;
              lvl_add = 2'd2;
              if (wr_compact8)
                commit_pair = '{right: top_align8(wr_data[15:8]), left: top_align8(wr_data[7:0])};
              else
                commit_pair = '{right: top_align16(wr_data[31:16]), left: top_align16(wr_data[15:0])};
            end
          end
        end
        MODE_MONO: begin
          if (!staged) begin
            if (full) begin
              ovf_evt = 1'b1;
            end else begin
              commit      = 1'b1;
              lvl_add     = 2'd2;
              commit_pair = '{right: wr_data, left: wr_data};
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      staged <= 1'b0;
      hold   <= '0;
    end else if (stage_set) begin
      staged <= 1'b1;
      hold   <= wr_data;
    end else if (stage_clr) begin
      staged <= 1'b0;
    end
  end

  // R6
  left_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && wr_mode == 2'd0 && !staged && !full) |=> next_right);

  // R9
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && staged && wr_mode != 2'd0) |=> (next_right && $stable(hold)));
endmodule

// File: rtl/afifo_pair_ram.sv
module afifo_pair_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/afifo_unpack.sv
module afifo_unpack
  import afifo_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                rd_en,
  input  logic                avail,
  input  pair_t               pair_q,
  output logic                take,
  output logic                pop,
  output logic                head_half,
  output logic                rd_valid,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                rd_right,
  output logic                rd_empty
);
  logic sel_q;

  assign take = rd_en && avail && !flush;
  assign pop  = take && head_half;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_half <= 1'b0;
      rd_valid  <= 1'b0;
      sel_q     <= 1'b0;
      rd_empty  <= 1'b0;
    end else begin
      rd_valid <= take;
      sel_q    <= head_half;
      rd_empty <= rd_en && !avail;
      if (take) head_half <= ~head_half;
    end
  end

  assign rd_right = rd_valid && sel_q;
  assign rd_data  = !rd_valid ? '0 : (sel_q ? pair_q.right : pair_q.left);

  // R10
  empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, rd_empty}));

  // R10
  empty_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !avail && !flush) |=> (rd_empty && rd_data == '0));
endmodule

// File: rtl/afifo_tx.sv
module afifo_tx
  import afifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(2*DEPTH+1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [1:0]          wr_mode,
  input  logic                wr_compact8,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                next_right,
  input  logic                rd_en,
  output logic                rd_valid,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                rd_right,
  output logic                rd_empty,
  output logic [LW-1:0]       level,
  output logic                overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          full, avail;
  logic          commit, ovf_evt, take, pop, head_half;
  logic [1:0]    lvl_add;
  pair_t         commit_pair, pair_q;
  logic [LW-1:0] lvl_expect;

  assign full  = (count == CW'(DEPTH));
  assign avail = (count != '0);

  afifo_packer u_pack (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_compact8(wr_compact8), .wr_data(wr_data),
    .full(full), .commit(commit), .commit_pair(commit_pair),
    .lvl_add(lvl_add), .ovf_evt(ovf_evt), .next_right(next_right)
  );

  afifo_pair_ram #(.DEPTH(DEPTH), .W(2*SAMPLE_W)) u_ram (
    .clk(clk), .we(commit), .waddr(wptr), .wdata(commit_pair),
    .raddr(rptr), .rdata(pair_q)
  );

  afifo_unpack u_unpack (
    .clk(clk), .rst(rst), .flush(flush),
    .rd_en(rd_en), .avail(avail), .pair_q(pair_q),
    .take(take), .pop(pop), .head_half(head_half),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_right(rd_right), .rd_empty(rd_empty)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (commit) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)    rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(commit) - CW'(pop);
      level <= level + LW'(lvl_add) - LW'(take);
      if (ovf_evt) overflow <= 1'b1;
    end
  end

  assign lvl_expect = LW'({count, 1'b0}) + LW'(next_right) - LW'(head_half);

  // R5
  lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(2*DEPTH));

  // R5
  lvl_balance_chk: assert property (@(posedge clk) disable iff (rst)
    level == lvl_expect);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> !full);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !flush) |=> overflow);

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0 && !overflow && !next_right && !rd_valid));
endmodule

// File: tb/tb_afifo_tx.sv
`timescale 1ns/1ps
module tb_afifo_tx;
  localparam int DEPTH = 8;
  localparam int LW    = $clog2(2*DEPTH+1);

  logic          clk = 1'b0;
  logic          rst, flush, wr_en, wr_compact8, rd_en;
  logic [1:0]    wr_mode;
  logic [31:0]   wr_data;
  logic          next_right, rd_valid, rd_right, rd_empty, overflow;
  logic [31:0]   rd_data;
  logic [LW-1:0] level;

  always #5 clk = ~clk;

  afifo_tx #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_compact8(wr_compact8), .wr_data(wr_data),
    .next_right(next_right),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_right(rd_right),
    .rd_empty(rd_empty), .level(level), .overflow(overflow)
  );

  int tests = 0;
  int fails = 0;

  // reference model
  logic [63:0] mq[$];
  bit          m_half, m_staged, m_ovf;
  logic [31:0] m_hold;
  bit          e_valid, e_empty, e_right;
  logic [31:0] e_data;
  int          e_level;

  function automatic logic [31:0] al16(input logic [15:0] s); return {s, 16'h0}; endfunction
  function automatic logic [31:0] al8(input logic [7:0] s);   return {s, 24'h0}; endfunction

  task automatic model(input bit we, input logic [1:0] md, input bit c8,
                       input logic [31:0] d, input bit re, input bit fl);
    bit full;
    e_valid = 0; e_empty = 0; e_right = 0; e_data = 0;
    if (fl) begin
      mq.delete(); m_half = 0; m_staged = 0; m_ovf = 0;
    end else begin
      full = (mq.size() == DEPTH);
      if (re) begin
        if (mq.size() > 0) begin
          e_valid = 1; e_right = m_half;
          e_data  = m_half ? mq[0][63:32] : mq[0][31:0];
          if (m_half) begin void'(mq.pop_front()); m_half = 0; end
          else m_half = 1;
        end else e_empty = 1;
      end
      if (we) begin
        case (md)
          2'd0: if (m_staged) begin mq.push_back({d, m_hold}); m_staged = 0; end
                else if (full) m_ovf = 1;
                else begin m_staged = 1; m_hold = d; end
          2'd1: if (!m_staged) begin
                  if (full) m_ovf = 1;
                  else if (c8) mq.push_back({al8(d[15:8]), al8(d[7:0])});
                  else mq.push_back({al16(d[31:16]), al16(d[15:0])});
                end
          2'd2: if (!m_staged) begin
                  if (full) m_ovf = 1; else mq.push_back({d, d});
                end
          default: ;
        endcase
      end
    end
    e_level = 2*mq.size() + int'(m_staged) - int'(m_half);
  endtask

  task automatic check(input string tag);
    tests++;
    if (rd_valid !== e_valid || rd_empty !== e_empty || rd_data !== e_data ||
        (e_valid && rd_right !== e_right) || int'(level) != e_level ||
        next_right !== m_staged || overflow !== m_ovf) begin
      fails++;
      $display("FAIL %s: act v%0b e%0b r%0b d%08h lvl%0d nr%0b ov%0b exp v%0b e%0b r%0b d%08h lvl%0d nr%0b ov%0b",
               tag, rd_valid, rd_empty, rd_right, rd_data, level, next_right, overflow,
               e_valid, e_empty, e_right, e_data, e_level, m_staged, m_ovf);
    end
  endtask

  task automatic step(input bit we, input logic [1:0] md, input bit c8,
                      input logic [31:0] d, input bit re, input bit fl, input string tag);
    wr_en = we; wr_mode = md; wr_compact8 = c8; wr_data = d; rd_en = re; flush = fl;
    model(we, md, c8, d, re, fl);
    @(negedge clk);
    check(tag);
    wr_en = 0; rd_en = 0; flush = 0;
  endtask

  task automatic wr(input logic [1:0] md, input bit c8, input logic [31:0] d, input string tag);
    step(1, md, c8, d, 0, 0, tag);
  endtask

  task automatic rd(input string tag);
    step(0, 2'd0, 0, 32'h0, 1, 0, tag);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: act timeout exp completion");
    finish_run();
  end

  initial begin
    rst = 1; flush = 0; wr_en = 0; rd_en = 0; wr_mode = 0; wr_compact8 = 0; wr_data = 0;
    m_half = 0; m_staged = 0; m_ovf = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    step(0, 0, 0, 0, 0, 0, "R6 R5 reset state");

    // R1 stereo ordering and alignment
    wr(2'd0, 0, 32'hA1A2A3A4, "R6 left staged");
    wr(2'd0, 0, 32'hB1B2B3B4, "R1 right commit");
    rd("R1 left read");
    rd("R1 right read");

    // R7 lone left is counted but unreadable
    wr(2'd0, 0, 32'h11112222, "R7 lone left");
    rd("R7 empty while left waits");
    wr(2'd0, 0, 32'h33334444, "R7 partner arrives");
    rd("R7 left read"); rd("R7 right read");

    // R2 compact 16
    wr(2'd1, 0, 32'hBEEF1234, "R2 compact16 write");
    rd("R2 left"); rd("R2 right");

    // R3 compact 8
    wr(2'd1, 1, 32'hFFFF5A3C, "R3 compact8 write");
    rd("R3 left"); rd("R3 right");

    // R4 mono and R5 scale
    for (int i = 0; i < 4; i++) wr(2'd2, 0, 32'hCAFE0000 + i, "R5 mono count");
    for (int i = 0; i < 8; i++) rd("R4 mono repeat");

    // R9 ignored writes while left staged, reserved mode
    wr(2'd0, 0, 32'h0000AAAA, "R9 left");
    wr(2'd1, 0, 32'h12345678, "R9 compact ignored");
    wr(2'd2, 0, 32'h87654321, "R9 mono ignored");
    wr(2'd3, 0, 32'hDEADBEEF, "R9 reserved ignored");
    wr(2'd0, 0, 32'h0000BBBB, "R9 right");
    wr(2'd3, 0, 32'hDEADBEEF, "R9 reserved ignored empty");
    rd("R9 left kept"); rd("R9 right kept"); rd("R9 nothing else");

    // R8 full, drop, sticky, same-cycle read and write at full
    for (int i = 0; i < 8; i++) wr(2'd2, 0, 32'h50000000 + i, "R8 fill");
    wr(2'd2, 0, 32'h5FFFFFFF, "R8 mono dropped");
    wr(2'd0, 0, 32'h5EEEEEEE, "R8 left dropped");
    rd("R8 read left head");
    step(1, 2'd1, 0, 32'h77778888, 1, 0, "R8 write with popping read at full");
    step(1, 2'd1, 0, 32'h9999AAAA, 0, 0, "R8 write after room");
    for (int i = 0; i < 16; i++) rd("R12 drain order");

    // R10 empty read
    rd("R10 empty read");
    rd("R10 empty read again");

    // R11 flush beats write and read
    wr(2'd2, 0, 32'h01010101, "R11 preload");
    wr(2'd0, 0, 32'h02020202, "R11 preload left");
    step(1, 2'd0, 0, 32'h03030303, 1, 1, "R11 flush with traffic");
    rd("R11 empty after flush");

    // constrained random, R12
    void'($urandom(32'h0A0D10F0));
    for (int i = 0; i < 4000; i++) begin
      bit we, re, fl, c8;
      logic [1:0] md;
      we = ($urandom_range(99) < 55);
      re = ($urandom_range(99) < 45);
      fl = ($urandom_range(999) < 4);
      c8 = $urandom_range(1);
      md = ($urandom_range(99) < 5) ? 2'd3 : 2'($urandom_range(2));
      step(we, md, c8, $urandom, re, fl, "R12 random");
    end

    finish_run();
  end
endmodule